// File: doc/BRIEF.md
# Masked Packed Funnel-Shift-Left Unit

This block is a SIMD datapath for a 512-bit vector register. Each element lane places the destination element in the upper half of a double-width value and the second source element in the lower half. It shifts that value left by a per-lane count and keeps only the upper half. Lanes can be 16, 32 or 64 bits wide. The active vector length can be 128, 256 or 512 bits. A lane mask chooses which lanes take the shifted value. Each remaining lane is either cleared or keeps its destination value.

An issue strobe captures all operands in one clock. The result and a one-cycle valid pulse appear on the next clock. The element size comes from an opcode byte and a width bit. The count for a lane can come from that lane's own count element, or, in broadcast mode, from element 0 of the count vector. The result stays on the output until the next issue.

Top module: `funnel_shl_unit`

## Requirements
- R1: For each active lane selected by the mask, the result is the upper W bits of {dst lane, src lane} shifted left by the effective count, where W is the lane width.
- R2: The effective count is the count element ANDed with W-1 (15, 31 or 63). A count of W or more wraps: W behaves as 0 and W+1 behaves as 1.
- R3: The lane width is decoded from `opc_i` and `wide_i` as follows: 0x70 with `wide_i`=1 gives 16 bits, 0x71 with `wide_i`=0 gives 32 bits, and 0x71 with `wide_i`=1 gives 64 bits. Any other combination gives an all-zero result.
- R4: `vlen_i` selects the active vector length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. Every result bit at or above the active length is zero, whatever the mask.
- R5: With `mask_en_i`=1, bit j of `mask_i` controls lane j. Mask bits for lanes beyond the active lane count have no effect. With `mask_en_i`=0, every active lane takes the shifted value.
- R6: An active lane whose mask bit is 0 reads zero when `zero_i`=1 and keeps its `dst_i` element when `zero_i`=0.
- R7: With `bcast_i`=1 and 32-bit or 64-bit lanes, every lane uses the low element of `cnt_i` as its count. For 16-bit lanes, `bcast_i` has no effect.
- R8: `res_o` and `vld_o` update on the clock after `start_i`=1. `vld_o` is high for exactly one cycle per issue, and `res_o` holds its value while `start_i` is low.
- R9: While `rst_n` is low, `res_o` is zero and `vld_o` is zero.
- R10: A lane with effective count 0 returns its `dst_i` element unchanged. The `src_i` element has no influence on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Issue strobe; operands are captured when high |
| dst_i | input | 512 | Destination vector (upper funnel half and merge source) |
| src_i | input | 512 | Second source vector (lower funnel half) |
| cnt_i | input | 512 | Per-lane shift counts |
| mask_i | input | 32 | Lane mask, bit j for lane j |
| mask_en_i | input | 1 | Enables masking |
| zero_i | input | 1 | 1 clears unselected lanes, 0 keeps the destination |
| bcast_i | input | 1 | Use count element 0 for all lanes (32/64-bit lanes only) |
| opc_i | input | 8 | Opcode byte for the lane-width decode |
| wide_i | input | 1 | Width bit for the lane-width decode |
| vlen_i | input | 2 | Vector length select |
| res_o | output | 512 | Registered result vector |
| vld_o | output | 1 | One-cycle result valid |

## Verification
The sweeps drive counts of exactly W-1, W and W+1 for each lane width, and random counts that overflow every lane. A design that saturates instead of wrapping, or that masks with the wrong width, fails these sweeps. Count-zero lanes are paired with random `src_i`, so a shifter that leaks the lower half into the result (for example, by a right shift of the full width) is exposed. Masks are random and include bits above the active lanes, under every vector length. This catches length clearing that depends on the mask, and merge or zero modes that are swapped. Broadcast is driven together with distinct per-lane counts at every lane width: a design that applies broadcast to 16-bit lanes, or never applies it, produces wrong lanes. Invalid opcode and width combinations must produce a zero vector.

// File: rtl/funnel_shl_unit.sv
module funnel_shl_unit #(
  parameter int VEC_W = 512,
  parameter int BLK_W = 128,
  parameter logic [7:0] OPC_NARROW = 8'h70,
  parameter logic [7:0] OPC_WIDE = 8'h71
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] cnt_i,
  input  logic [VEC_W/16-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic             zero_i,
  input  logic             bcast_i,
  input  logic [7:0]       opc_i,
  input  logic             wide_i,
  input  logic [1:0]       vlen_i,
  output logic [VEC_W-1:0] res_o,
  output logic             vld_o
);
  localparam int NBLK = VEC_W / BLK_W;

  logic [2:0][VEC_W-1:0] var_res;
  logic [VEC_W-1:0] len_keep;
  logic [VEC_W-1:0] res_n;
  int blk_active;

  wire sz16 = (opc_i == OPC_NARROW) && wide_i;
  wire sz32 = (opc_i == OPC_WIDE) && !wide_i;
  wire sz64 = (opc_i == OPC_WIDE) && wide_i;

  for (genvar s = 0; s < 3; s++) begin : g_size
    localparam int W  = 16 << s;
    localparam int NL = VEC_W / W;
    localparam int CB = 4 + s;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      wire [W-1:0]   d_w   = dst_i[j*W +: W];
      wire [CB-1:0]  c_w   = (s != 0 && bcast_i) ? cnt_i[CB-1:0] : cnt_i[j*W +: CB];
      wire [2*W-1:0] cat_w = {d_w, src_i[j*W +: W]} << c_w;
      wire           sel_w = !mask_en_i || mask_i[j];
      assign var_res[s][j*W +: W] = sel_w ? cat_w[2*W-1:W] : (zero_i ? '0 : d_w);
    end
  end

  always_comb begin
    case (vlen_i)
      2'd0:    blk_active = 1;
      2'd1:    blk_active = 2;
      default: blk_active = NBLK;
    endcase
  end

  for (genvar k = 0; k < NBLK; k++) begin : g_len
    assign len_keep[k*BLK_W +: BLK_W] = {BLK_W{k < blk_active}};
  end

  always_comb begin
    if (sz16)      res_n = var_res[0];
    else if (sz32) res_n = var_res[1];
    else if (sz64) res_n = var_res[2];
    else           res_n = '0;
    res_n = res_n & len_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= start_i;
      if (start_i) res_o <= res_n;
    end
  end
endmodule

module funnel_shl_chk #(
  parameter int VEC_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [VEC_W-1:0] dst_i,
  input logic [VEC_W-1:0] cnt_i,
  input logic [VEC_W/16-1:0] mask_i,
  input logic             mask_en_i,
  input logic             zero_i,
  input logic [7:0]       opc_i,
  input logic             wide_i,
  input logic [1:0]       vlen_i,
  input logic [VEC_W-1:0] res_o,
  input logic             vld_o
);
  wire n16 = (opc_i == 8'h70) && wide_i;
  wire bad = !(n16 || (opc_i == 8'h71));

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> vld_o); // R8
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> !vld_o); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> $stable(res_o)); // R8
  AST_LEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && vlen_i == 2'd0) |=> (res_o[VEC_W-1:128] == '0)); // R4
  AST_BAD_OPC: assert property (@(posedge clk) disable iff (!rst_n) (start_i && bad) |=> (res_o == '0)); // R3
  AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && n16 && mask_en_i && zero_i && !mask_i[0]) |=> (res_o[15:0] == '0)); // R6
  AST_MERGE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && n16 && mask_en_i && !zero_i && !mask_i[0]) |=> (res_o[15:0] == $past(dst_i[15:0]))); // R6
  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && n16 && !mask_en_i && cnt_i[3:0] == 4'd0) |=> (res_o[15:0] == $past(dst_i[15:0]))); // R10
endmodule

bind funnel_shl_unit funnel_shl_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/funnel_shl_unit_bench.sv
module funnel_shl_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [511:0] dst_i = '0, src_i = '0, cnt_i = '0;
  logic [31:0] mask_i = '0;
  logic mask_en_i = 1'b0, zero_i = 1'b0, bcast_i = 1'b0, wide_i = 1'b0;
  logic [7:0] opc_i = '0;
  logic [1:0] vlen_i = '0;
  logic [511:0] res_o;
  logic vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  funnel_shl_unit u_funnel_shl_unit (.*);

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] model(logic [511:0] d, logic [511:0] s, logic [511:0] c,
                                         logic [31:0] m, bit men, bit zm, bit bc,
                                         logic [7:0] op, bit w, logic [1:0] vl);
    logic [511:0] r = '0;
    int lw, vbits;
    logic [63:0] wm, dl, sl, cl, ol;
    if (op == 8'h70 && w) lw = 16;
    else if (op == 8'h71 && !w) lw = 32;
    else if (op == 8'h71 && w) lw = 64;
    else return '0;
    vbits = (vl == 0) ? 128 : (vl == 1) ? 256 : 512;
    wm = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
    for (int j = 0; j < 512 / lw; j++) begin
      if (j * lw < vbits) begin
        dl = 64'(d >> (j * lw)) & wm;
        sl = 64'(s >> (j * lw)) & wm;
        cl = ((bc && lw != 16) ? 64'(c) : 64'(c >> (j * lw))) & 64'(lw - 1);
        if (!men || m[j]) ol = (cl == 0) ? dl : (((dl << cl) | (sl >> (lw - cl))) & wm);
        else ol = zm ? 64'd0 : dl;
        r = r | ({448'd0, ol} << (j * lw));
      end
    end
    return r;
  endfunction

  task automatic check512(string tag, logic [511:0] act, logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, bit hold_chk);
    logic [511:0] exp;
    exp = model(dst_i, src_i, cnt_i, mask_i, mask_en_i, zero_i, bcast_i, opc_i, wide_i, vlen_i);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check1({tag, " vld"}, vld_o, 1'b1);
    check512(tag, res_o, exp);
    if (hold_chk) begin
      dst_i = rnd512();
      @(negedge clk);
      check1("R8 vld pulse", vld_o, 1'b0);
      check512("R8 hold", res_o, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check512("R9 reset res", res_o, '0);
    check1("R9 reset vld", vld_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 directed: zero count, random src
    opc_i = 8'h70; wide_i = 1'b1; vlen_i = 2'd2;
    dst_i = rnd512(); src_i = rnd512(); cnt_i = '0;
    issue("R10 cnt0", 1'b1);

    // R3 invalid decodes
    opc_i = 8'h70; wide_i = 1'b0; dst_i = rnd512(); cnt_i = rnd512();
    issue("R3 bad w", 1'b0);
    opc_i = 8'h72; wide_i = 1'b1;
    issue("R3 bad opc", 1'b1);

    for (int sz = 0; sz < 3; sz++)
      for (int vl = 0; vl < 4; vl++)
        for (int mm = 0; mm < 3; mm++)
          for (int bc = 0; bc < 2; bc++)
            for (int cm = 0; cm < 4; cm++)
              for (int rp = 0; rp < 3; rp++) begin
                int lw;
                string tg;
                lw = 16 << sz;
                opc_i = (sz == 0) ? 8'h70 : 8'h71;
                wide_i = (sz != 1);
                vlen_i = 2'(vl);
                mask_en_i = (mm != 0);
                zero_i = (mm == 2);
                bcast_i = bc[0];
                mask_i = $urandom;
                dst_i = rnd512(); src_i = rnd512();
                cnt_i = rnd512();
                for (int j = 0; j < 512 / lw; j++) begin
                  int cv;
                  cv = (cm == 1) ? 0 : (cm == 2) ? lw - 1 : (cm == 3) ? lw + rp : 0;
                  if (cm != 0) cnt_i[j*lw +: 16] = 16'(cv);
                end
                tg = $sformatf("R1 R3 R4 R5 sz%0d vl%0d", lw, vl);
                if (cm != 0) tg = {tg, " R2"};
                if (cm == 1) tg = {tg, " R10"};
                if (mm != 0) tg = {tg, " R6"};
                if (bc != 0) tg = {tg, " R7"};
                issue(tg, (rp == 0));
              end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule